// File: doc/BRIEF.md
# Serial Addressed Trim Register Bank

This block is the digital front end of a multi-channel trim converter. A three-wire serial port (serial clock, serial data, load strobe) fills a twelve-stage shift register. When the load strobe rises, the top four stages are read as a channel address and the bottom eight stages are copied into the channel holding register that the address selects. The eight channel values are presented in parallel, ready for the converters.

The far end of the shift register drives a serial output. Several devices can therefore be wired in series and loaded as one long shift register, and one shared strobe updates all of them. An active-low preset drives every channel to midscale at once, whatever the serial port is doing.

Every serial-side input is brought into the system clock domain through a synchronizer. The serial clock and the load strobe are edge-detected. The preset is applied asynchronously and released synchronously.

Top module: `serial_trim_bank`

## Requirements
- R1: A frame is twelve bits, sampled on rising serial clock edges. The first four bits are the address and the last eight are the value, each field sent most-significant bit first. After twelve edges the address occupies shift stages 11..8 and the value stages 7..0.
- R2: On a load, address code k with 1 <= k <= 8 writes the value into channel k-1. Channel i is `ch_value[8*i+7:8*i]`, and every other channel keeps its value.
- R3: Address code 0 and codes 9 through 15 are no-operation codes: a load with one of them leaves every channel unchanged.
- R4: `ser_dout` presents the most-significant shift stage. A bit captured on a serial edge appears on `ser_dout` after eleven further edges, so a downstream device captures it on the twelfth.
- R5: Each rising edge of the load strobe performs exactly one transfer. A strobe held high does not repeat the transfer.
- R6: Serial clock edges that arrive while the load strobe is high are ignored, and the shift register does not change.
- R7: With no serial clock edge and no load edge, the shift register and all channels hold their values.
- R8: While `preset_n` is low, every channel reads 0x80, starting before the next system clock edge. Loads made during that time change no channel.
- R9: The synchronous reset `rst` clears the shift register to zero and sets every channel to 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_din | input | 1 | Serial data in |
| ser_load | input | 1 | Active-high transfer strobe |
| preset_n | input | 1 | Active-low midscale preset of all channels |
| ser_dout | output | 1 | Serial data out, for chaining to the next device |
| ch_value | output | 64 | Eight packed 8-bit channel values, channel 0 in the low byte |

## Verification
The bench builds the block with its default parameters: eight channels, a four-bit address and a two-stage synchronizer. With these values every one of the sixteen address codes can be driven, including all of the no-operation codes on both sides of the valid range. The serial output is read back by shifting zeros through the register. This reveals the captured contents after loads, after clock edges blocked by the strobe, and after reset. The preset is checked for its immediate effect, for blocking loads while low, and for loads once it is released.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int DEF_ADDR_W  = 4;
    localparam int DEF_DATA_W  = 8;
    localparam int DEF_N_CH    = 8;
    localparam int DEF_SYNC    = 2;

    // Synchronized serial-port controls after edge detection
    typedef struct packed {
        logic din;
        logic clk_rise;
        logic load_lvl;
        logic load_rise;
    } ser_ctl_t;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_LOAD    = 2'd2,
        OP_BLOCKED = 2'd3
    } ser_op_t;

    // Channel slot for an address code, or -1 for a no-operation code
    function automatic int slot_of(input int code, input int n_ch);
        if (code >= 1 && code <= n_ch)
            return code - 1;
        return -1;
    endfunction

    function automatic ser_op_t classify(input ser_ctl_t c);
        if (c.load_rise)
            return OP_LOAD;
        if (c.clk_rise && c.load_lvl)
            return OP_BLOCKED;
        if (c.clk_rise)
            return OP_SHIFT;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/trim_sync_edge.sv
module trim_sync_edge #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [STAGES-1:0][W-1:0] pipe_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
            prev_q <= '0;
        end else begin
            pipe_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++)
                pipe_q[s] <= pipe_q[s-1];
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign lvl  = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/trim_shift_chain.sv
module trim_shift_chain #(
    parameter int LEN = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] stages,
    output logic           dout
);
    logic [LEN-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (shift_en)
            sr_q <= {sr_q[LEN-2:0], din};
    end

    assign stages = sr_q;
    assign dout   = sr_q[LEN-1];
endmodule

// File: rtl/trim_preset_ctrl.sv
module trim_preset_ctrl #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic preset_n,
    output logic preset_act
);
    logic [STAGES-1:0] hold_q;

    // Asserts at once when preset_n falls, releases after STAGES clocks
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)
            hold_q <= '1;
        else if (rst)
            hold_q <= '0;
        else
            hold_q <= {hold_q[STAGES-2:0], 1'b0};
    end

    assign preset_act = hold_q[STAGES-1];
endmodule

// File: rtl/trim_channel_bank.sv
module trim_channel_bank #(
    parameter int N_CH   = 8,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   preset_act,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    output logic [N_CH*DATA_W-1:0] ch_flat
);
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [DATA_W-1:0] ch_q;

        always_ff @(posedge clk or posedge preset_act) begin
            if (preset_act)
                ch_q <= MID;
            else if (rst)
                ch_q <= MID;
            else if (wr_en && wr_sel == SEL_W'(i))
                ch_q <= wr_data;
        end

        assign ch_flat[i*DATA_W +: DATA_W] = ch_q;
    end
endmodule

// File: rtl/serial_trim_bank.sv
module serial_trim_bank
    import trim_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int N_CH   = DEF_N_CH,
    parameter int SYNC   = DEF_SYNC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    input  logic                   ser_load,
    input  logic                   preset_n,
    output logic                   ser_dout,
    output logic [N_CH*DATA_W-1:0] ch_value
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int SEL_W   = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic [2:0]         s_lvl;
    logic [2:0]         s_rise;
    ser_ctl_t           ctl;
    ser_op_t            op;
    logic               shift_pulse;
    logic               load_pulse;
    logic               load_lvl;
    logic               preset_act;
    logic [FRAME_W-1:0] sr_q;
    logic [ADDR_W-1:0]  addr_f;
    logic [DATA_W-1:0]  data_f;
    int                 slot;
    logic               wr_en;
    logic [SEL_W-1:0]   wr_sel;

    // bit 2: data, bit 1: serial clock, bit 0: load strobe
    trim_sync_edge #(.W(3), .STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_din, ser_clk, ser_load}),
        .lvl      (s_lvl),
        .rise     (s_rise)
    );

    always_comb begin
        ctl.din       = s_lvl[2];
        ctl.clk_rise  = s_rise[1];
        ctl.load_lvl  = s_lvl[0];
        ctl.load_rise = s_rise[0];
        op            = classify(ctl);
    end

    assign shift_pulse = (op == OP_SHIFT);
    assign load_pulse  = (op == OP_LOAD);
    assign load_lvl    = ctl.load_lvl;

    trim_shift_chain #(.LEN(FRAME_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_pulse),
        .din      (ctl.din),
        .stages   (sr_q),
        .dout     (ser_dout)
    );

    trim_preset_ctrl #(.STAGES(SYNC)) u_preset (
        .clk        (clk),
        .rst        (rst),
        .preset_n   (preset_n),
        .preset_act (preset_act)
    );

    always_comb begin
        addr_f = sr_q[FRAME_W-1 -: ADDR_W];
        data_f = sr_q[DATA_W-1:0];
        slot   = slot_of(int'(addr_f), N_CH);
        wr_en  = load_pulse && (slot >= 0);
        wr_sel = (slot >= 0) ? SEL_W'(slot) : '0;
    end

    trim_channel_bank #(.N_CH(N_CH), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .preset_act (preset_act),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (data_f),
        .ch_flat    (ch_value)
    );
endmodule

// File: rtl/serial_trim_bank_chk.sv
module serial_trim_bank_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int N_CH   = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       preset_n,
    input logic                       ser_dout,
    input logic [N_CH*DATA_W-1:0]     ch_value,
    input logic [ADDR_W+DATA_W-1:0]   sr_q,
    input logic                       shift_pulse,
    input logic                       load_pulse,
    input logic                       load_lvl,
    input logic                       preset_act
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

    logic [ADDR_W-1:0] code;
    logic              hit;
    logic              all_mid;
    logic              hit_q;
    int                idx_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        code    = sr_q[FRAME_W-1:DATA_W];
        hit     = (code != '0) && (int'(code) <= N_CH);
        all_mid = 1'b1;
        for (int i = 0; i < N_CH; i++)
            if (ch_value[i*DATA_W +: DATA_W] != MID)
                all_mid = 1'b0;
    end

    always_ff @(posedge clk) begin
        hit_q  <= load_pulse && hit && !preset_act;
        idx_q  <= int'(code) - 1;
        data_q <= sr_q[DATA_W-1:0];
    end

    // R2: a valid load lands in its channel
    a_r2_load_lands: assert property (@(posedge clk) disable iff (rst || !preset_n)
        hit_q |-> ch_value[idx_q*DATA_W +: DATA_W] == data_q);

    // R3: no-operation code leaves channels alone
    a_r3_noop_stable: assert property (@(posedge clk) disable iff (rst || !preset_n)
        (load_pulse && !hit && !preset_act) |=> $stable(ch_value));

    // R4: output follows the stage below the top after a shift
    a_r4_dout_follow: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> ser_dout == $past(sr_q[FRAME_W-2]));

    // R5: one transfer per strobe edge
    a_r5_single_load: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);

    // R6: no shifting while the strobe is high
    a_r6_no_shift_in_load: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |-> !load_lvl);

    // R7: register holds without a shift
    a_r7_hold_sr: assert property (@(posedge clk) disable iff (rst)
        !shift_pulse |=> $stable(sr_q));

    // R8: preset forces midscale
    a_r8_preset_mid: assert property (@(posedge clk) disable iff (rst)
        !preset_n |-> all_mid);
endmodule

bind serial_trim_bank serial_trim_bank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_CH   (N_CH)
) u_chk (.*);

// File: tb/serial_trim_bank_bench.sv
module serial_trim_bank_bench;
    localparam int NCH = 8;

    logic        clk = 0;
    logic        rst = 1;
    logic        ser_clk = 0, ser_din = 0, ser_load = 0, preset_n = 1;
    logic        ser_dout;
    logic [63:0] ch_value;

    always #4 clk = ~clk;

    serial_trim_bank u_serial_trim_bank (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load(ser_load), .preset_n(preset_n),
        .ser_dout(ser_dout), .ch_value(ch_value)
    );

    typedef struct {
        string       req;
        bit          is_dout;
        int          idx;
        logic [7:0]  exp;
    } item_t;

    item_t       exp_q[$];
    int          n_cmp = 0, n_bad = 0;
    bit          drain_req = 0;
    bit          done = 0;
    logic [7:0]  m_ch[NCH];
    logic [11:0] m_sr;
    bit          m_preset = 0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_ch(string req, int idx);
        item_t it;
        it.req = req; it.is_dout = 0; it.idx = idx; it.exp = m_ch[idx];
        exp_q.push_back(it);
    endtask

    task automatic push_all(string req);
        for (int i = 0; i < NCH; i++) push_ch(req, i);
    endtask

    task automatic push_dout(string req);
        item_t it;
        it.req = req; it.is_dout = 1; it.idx = 0; it.exp = {7'd0, m_sr[11]};
        exp_q.push_back(it);
    endtask

    task automatic drain();
        drain_req = 1;
        wait (drain_req == 0);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            wait (drain_req == 1);
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                act = it.is_dout ? {7'd0, ser_dout} : ch_value[it.idx*8 +: 8];
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s%0d actual=%h expected=%h", it.req,
                             it.is_dout ? "dout" : "ch", it.idx, act, it.exp);
                end
            end
            drain_req = 0;
        end
    end

    task automatic shift_bit(bit b, string req);
        ser_din = b;
        tick(3);
        ser_clk = 1;
        tick(6);
        if (!ser_load) m_sr = {m_sr[10:0], b};
        ser_clk = 0;
        tick(3);
        push_dout(req);
        drain();
    endtask

    task automatic load_strobe();
        ser_load = 1;
        tick(6);
        if (!m_preset && m_sr[11:8] >= 1 && m_sr[11:8] <= 8)
            m_ch[m_sr[11:8] - 1] = m_sr[7:0];
        ser_load = 0;
        tick(3);
    endtask

    task automatic send(logic [3:0] a, logic [7:0] d, string req);
        for (int i = 3; i >= 0; i--) shift_bit(a[i], req);
        for (int i = 7; i >= 0; i--) shift_bit(d[i], req);
        load_strobe();
        push_all(req);
        drain();
    endtask

    task automatic flush_zeros(string req);
        for (int i = 0; i < 12; i++) shift_bit(1'b0, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) m_ch[i] = 8'h80;
        m_sr = '0;
        tick(4);
        rst = 0;
        tick(2);
        // R9: reset state
        push_all("R9");
        push_dout("R9");
        drain();

        // R1, R2: each channel gets a distinct value
        for (int c = 1; c <= 8; c++)
            send(4'(c), 8'(8'h11 * c + 8'h03), "R2");

        // R1: bit order within a field
        send(4'd5, 8'h01, "R1");
        send(4'd3, 8'hFE, "R1");

        // R3: no-operation codes
        send(4'd0, 8'h55, "R3");
        for (int c = 9; c <= 15; c++)
            send(4'(c), 8'hA5, "R3");

        // R4: contents emerge at the output after the frame
        send(4'd8, 8'hC3, "R4");
        flush_zeros("R4");

        // R5: holding the strobe high does not repeat
        send(4'd2, 8'h3C, "R5");
        send(4'd0, 8'h00, "R5");
        ser_load = 1;
        tick(20);
        ser_load = 0;
        tick(4);
        push_all("R5");
        drain();

        // R6: clock edges under a high strobe are ignored
        for (int i = 3; i >= 0; i--) shift_bit(1'(4'd6 >> i), "R6");
        for (int i = 7; i >= 0; i--) shift_bit(1'(8'h9A >> i), "R6");
        ser_load = 1;
        tick(6);
        m_ch[5] = 8'h9A;
        for (int i = 0; i < 3; i++) shift_bit(1'b1, "R6");
        ser_load = 0;
        tick(4);
        push_all("R6");
        drain();
        flush_zeros("R6");

        // R7: idle hold
        tick(60);
        push_all("R7");
        push_dout("R7");
        drain();

        // R8: preset forces midscale before the next clock edge
        @(negedge clk);
        #1 preset_n = 0;
        m_preset = 1;
        #1;
        for (int i = 0; i < NCH; i++) begin
            n_cmp++;
            if (ch_value[i*8 +: 8] !== 8'h80) begin
                n_bad++;
                $display("FAIL R8 ch%0d actual=%h expected=80", i, ch_value[i*8 +: 8]);
            end
        end
        for (int i = 0; i < NCH; i++) m_ch[i] = 8'h80;
        send(4'd1, 8'h77, "R8");
        preset_n = 1;
        m_preset = 0;
        tick(5);
        send(4'd1, 8'h77, "R8");

        // R9: reset clears the shift register and presets channels
        send(4'd4, 8'hE1, "R9");
        for (int i = 3; i >= 0; i--) shift_bit(1'(4'd7 >> i), "R9");
        rst = 1;
        tick(3);
        rst = 0;
        m_sr = '0;
        for (int i = 0; i < NCH; i++) m_ch[i] = 8'h80;
        tick(2);
        push_all("R9");
        drain();
        flush_zeros("R9");

        finish_run();
    end
endmodule